// File: doc/BRIEF.md
# Split-Section Decade Counter

This block is a four-bit counter made of two sections that each have their own clock pin. The low section divides by two and drives `q[0]`. The high section divides by five and drives `q[3:1]`. Each section advances when its clock pin goes from high to low. The design does not use ripple clocking. Both section clocks are sampled by one free-running system clock, passed through a synchronizer and turned into single-cycle falling-edge strobes.

A build-time parameter chooses how the sections are joined:
- In the independent mode each section follows its own pin.
- In the decade (BCD) mode the high-to-low move of `q[0]` advances the high section. The high clock pin is then ignored, and `q` counts 0 to 9 in plain binary.
- In the bi-quinary mode the high-to-low move of `q[3]` advances the low section. The low clock pin is then ignored.

Two gated controls hold the outputs while they are active, and both override counting:
- The clear acts when both of its inputs are high.
- The preset acts when both of its inputs are high and loads nine.

Top module: `split_decade_counter`

## Requirements
- R1: A high-to-low transition on `lo_clk` toggles `q[0]` when the low section is fed from its pin. A low-to-high transition has no effect.
- R2: The high section holds a binary count on `q[3:1]` with `q[1]` as its least significant bit. Each advance steps the count 0,1,2,3,4 and then back to 0, so `q[3]` is high only at four.
- R3: In the independent mode (`CHAIN` = `CHAIN_NONE`), clock edges of one section never change the other section's outputs.
- R4: In the decade mode (`CHAIN` = `CHAIN_BCD`), `lo_clk` falls make `q` step 0..9 and then wrap to 0. The high section advances in the same cycle as `q[0]` goes from 1 to 0, and `hi_clk` has no effect.
- R5: In the bi-quinary mode (`CHAIN` = `CHAIN_BIQUINARY`), `hi_clk` falls make `q` step 0,2,4,6,8,1,3,5,7,9 and then back to 0. The low section toggles in the same cycle as `q[3]` falls, and `lo_clk` has no effect.
- R6: When `clr_a` and `clr_b` are both high at a system clock edge, `q` reads 0 after that edge. Either input high on its own has no effect.
- R7: When `nine_a` and `nine_b` are both high at a system clock edge, and the clear is not active, `q` reads 9 (binary 1001) after that edge. Either input high on its own has no effect.
- R8: When the clear and the preset are both active, the clear wins and `q` reads 0.
- R9: While the clear or the preset is active, section clock edges do not change `q`. Once the control is released, counting resumes from the held value with no pending step.
- R10: A section clock fall that is set up before system clock edge k appears on `q` after edge k+2, with `SYNC_STAGES` = 2. Before that edge `q` is unchanged.
- R11: While `rst_n` is low, `q` reads 0 and no step is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low system reset |
| lo_clk | input | 1 | Divide-by-two section clock, advances on its fall |
| hi_clk | input | 1 | Divide-by-five section clock, advances on its fall |
| clr_a | input | 1 | Clear gate input A |
| clr_b | input | 1 | Clear gate input B |
| nine_a | input | 1 | Preset-to-nine gate input A |
| nine_b | input | 1 | Preset-to-nine gate input B |
| q | output | 4 | Count outputs; q[0] is the low section, q[3:1] the high section |

## Verification
Two pairs of functions can fall in the same system cycle:
- The clear and the preset can be active at the same time. The bench raises all four gate inputs together on a counter that already reads nine, and expects zero.
- A detected section clock fall can arrive while a hold is active. The bench runs complete `lo_clk` and `hi_clk` pulses inside a clear window and inside a preset window, so that each strobe lands in a hold cycle. It then expects the held value both during the window and after the release.

The bench checks three instances, one per chaining mode, against arithmetic models that run in parallel.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [1:0] {
    CHAIN_NONE      = 2'd0,
    CHAIN_BCD       = 2'd1,
    CHAIN_BIQUINARY = 2'd2
  } chain_e;

  localparam int HI_MOD = 5;
  localparam int HI_W   = $clog2(HI_MOD);
  localparam logic [HI_W-1:0] HI_TOP = HI_W'(HI_MOD - 1);
  localparam int Q_W    = HI_W + 1;

  // next value of the divide-by-five section
  function automatic logic [HI_W-1:0] hi_next(input logic [HI_W-1:0] c);
    return (c == HI_TOP) ? '0 : c + 1'b1;
  endfunction

  // two-input AND gate of a control
  function automatic logic gate2(input logic a, input logic b);
    return a & b;
  endfunction

  function automatic logic [Q_W-1:0] pack_q(input logic lo, input logic [HI_W-1:0] hi);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/sdc_fall_detect.sv
module sdc_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[gi] <= 1'b0;
          else        sync_q[gi] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[gi] <= 1'b0;
          else        sync_q[gi] <= sync_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[LAST];
  end

  assign fall = prev_q & ~sync_q[LAST];

  // a fall strobe lasts exactly one system cycle
  p_fall_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

endmodule

// File: rtl/sdc_lo_stage.sv
module sdc_lo_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic clear,
  input  logic preset,
  output logic q_lo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_lo <= 1'b0;
    else if (clear)  q_lo <= 1'b0;
    else if (preset) q_lo <= 1'b1;
    else if (step)   q_lo <= ~q_lo;
  end

  p_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && !preset) |=> (q_lo != $past(q_lo)));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear && !preset) |=> $stable(q_lo));
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (q_lo == 1'b0));

endmodule

// File: rtl/sdc_hi_stage.sv
module sdc_hi_stage
  import sdc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            clear,
  input  logic            preset,
  output logic [HI_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (preset) cnt <= HI_TOP;
    else if (step)   cnt <= hi_next(cnt);
  end

  p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= HI_TOP);
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && !preset && cnt == HI_TOP) |=> (cnt == '0));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));

endmodule

// File: rtl/split_decade_counter.sv
module split_decade_counter
  import sdc_pkg::*;
#(
  parameter chain_e CHAIN       = CHAIN_BCD,
  parameter int     SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lo_clk,
  input  logic       hi_clk,
  input  logic       clr_a,
  input  logic       clr_b,
  input  logic       nine_a,
  input  logic       nine_b,
  output logic [3:0] q
);
  localparam bit LO_FROM_PIN = (CHAIN != CHAIN_BIQUINARY);
  localparam bit HI_FROM_PIN = (CHAIN != CHAIN_BCD);

  logic            pin_lo_fall, pin_hi_fall;
  logic            clear_evt, preset_evt, hold_evt;
  logic            q_lo;
  logic [HI_W-1:0] hi_cnt;
  logic            q0_fall_evt, q3_fall_evt;
  logic            lo_step, hi_step;

  sdc_fall_detect #(.STAGES(SYNC_STAGES)) u_lo_edge (
    .clk(clk), .rst_n(rst_n), .din(lo_clk), .fall(pin_lo_fall));
  sdc_fall_detect #(.STAGES(SYNC_STAGES)) u_hi_edge (
    .clk(clk), .rst_n(rst_n), .din(hi_clk), .fall(pin_hi_fall));

  assign clear_evt  = gate2(clr_a, clr_b);
  assign preset_evt = gate2(nine_a, nine_b) & ~clear_evt;
  assign hold_evt   = clear_evt | preset_evt;

  // output falls of a pin-driven section, used as the next section's strobe
  assign q0_fall_evt = pin_lo_fall & q_lo & ~hold_evt;
  assign q3_fall_evt = pin_hi_fall & (hi_cnt == HI_TOP) & ~hold_evt;

  assign lo_step = LO_FROM_PIN ? pin_lo_fall : q3_fall_evt;
  assign hi_step = HI_FROM_PIN ? pin_hi_fall : q0_fall_evt;

  sdc_lo_stage u_lo (
    .clk(clk), .rst_n(rst_n), .step(lo_step), .clear(clear_evt),
    .preset(preset_evt), .q_lo(q_lo));
  sdc_hi_stage u_hi (
    .clk(clk), .rst_n(rst_n), .step(hi_step), .clear(clear_evt),
    .preset(preset_evt), .cnt(hi_cnt));

  assign q = pack_q(q_lo, hi_cnt);

  p_clr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> (q == 4'd0));
  p_nine_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate2(nine_a, nine_b) && !gate2(clr_a, clr_b)) |=> (q == 4'd9));
  p_bcd_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (CHAIN == CHAIN_BCD) |-> (q <= 4'd9));
  p_bq_lo_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((CHAIN == CHAIN_BIQUINARY) && (q[0] != $past(q[0])) && !$past(hold_evt))
      |-> (($past(q[3:1]) == HI_TOP) && (q[3:1] == '0)));

endmodule

// File: tb/split_decade_counter_bench.sv
`timescale 1ns/1ps
module split_decade_counter_bench;
  import sdc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lo_clk = 1'b0, hi_clk = 1'b0;
  logic clr_a = 1'b0, clr_b = 1'b0, nine_a = 1'b0, nine_b = 1'b0;
  logic [3:0] q_bcd, q_ind, q_bq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // models
  int m_bcd;
  int m_ind_lo, m_ind_hi;
  int m_bq_lo, m_bq_hi;

  always #4 clk = ~clk;

  split_decade_counter #(.CHAIN(CHAIN_BCD)) u_split_decade_counter (
    .clk(clk), .rst_n(rst_n), .lo_clk(lo_clk), .hi_clk(hi_clk),
    .clr_a(clr_a), .clr_b(clr_b), .nine_a(nine_a), .nine_b(nine_b), .q(q_bcd));
  split_decade_counter #(.CHAIN(CHAIN_NONE)) u_split_decade_counter_ind (
    .clk(clk), .rst_n(rst_n), .lo_clk(lo_clk), .hi_clk(hi_clk),
    .clr_a(clr_a), .clr_b(clr_b), .nine_a(nine_a), .nine_b(nine_b), .q(q_ind));
  split_decade_counter #(.CHAIN(CHAIN_BIQUINARY)) u_split_decade_counter_bq (
    .clk(clk), .rst_n(rst_n), .lo_clk(lo_clk), .hi_clk(hi_clk),
    .clr_a(clr_a), .clr_b(clr_b), .nine_a(nine_a), .nine_b(nine_b), .q(q_bq));

  task automatic chk(input string req, input logic [3:0] act, input int exp);
    checks++;
    if (act !== 4'(exp)) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bcd_q();  return m_bcd;                      endfunction
  function automatic int ind_q();  return m_ind_hi * 2 + m_ind_lo;    endfunction
  function automatic int bq_q();   return m_bq_hi * 2 + m_bq_lo;      endfunction

  task automatic check_all(input string tag);
    chk({tag, " bcd"}, q_bcd, bcd_q());
    chk({tag, " ind"}, q_ind, ind_q());
    chk({tag, " bq"},  q_bq,  bq_q());
  endtask

  task automatic model_lo_fall();
    m_ind_lo = 1 - m_ind_lo;
    m_bcd    = (m_bcd + 1) % 10;
  endtask

  task automatic model_hi_fall();
    m_ind_hi = (m_ind_hi + 1) % 5;
    if (m_bq_hi == 4) m_bq_lo = 1 - m_bq_lo;
    m_bq_hi = (m_bq_hi + 1) % 5;
  endtask

  task automatic model_load(input int v);
    m_bcd = v;
    m_ind_lo = v % 2; m_ind_hi = v / 2;
    m_bq_lo  = v % 2; m_bq_hi  = v / 2;
  endtask

  task automatic pulse_lo();
    @(negedge clk) lo_clk = 1'b1;
    repeat (3) @(negedge clk);
    lo_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_hi();
    @(negedge clk) hi_clk = 1'b1;
    repeat (3) @(negedge clk);
    hi_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    model_load(0);
    repeat (5) @(negedge clk);
    chk("R11 reset bcd", q_bcd, 0);
    chk("R11 reset ind", q_ind, 0);
    chk("R11 reset bq",  q_bq,  0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R11 after release");

    // R1 R4: low clock sweep across the decade wrap; bq ignores lo_clk (R5)
    for (int i = 0; i < 12; i++) begin
      pulse_lo();
      model_lo_fall();
      check_all("R1 R4 R5 lo sweep");
    end

    // R2 R3 R5: high clock sweep, two full bi-quinary cycles; bcd ignores hi_clk (R4)
    for (int i = 0; i < 22; i++) begin
      pulse_hi();
      model_hi_fall();
      check_all("R2 R3 R5 hi sweep");
    end

    // R10 latency and R1 rising-edge immunity
    @(negedge clk) lo_clk = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 rising edge ignored");
    lo_clk = 1'b0;
    @(negedge clk);
    check_all("R10 edge k unchanged");
    @(negedge clk);
    check_all("R10 edge k+1 unchanged");
    @(negedge clk);
    model_lo_fall();
    check_all("R10 edge k+2 updated");
    repeat (3) @(negedge clk);

    // R6 single clear input has no effect, then gated clear
    clr_a = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R6 clr_a alone");
    clr_a = 1'b0; clr_b = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R6 clr_b alone");
    clr_a = 1'b1;
    @(negedge clk);
    model_load(0);
    check_all("R6 gated clear");
    clr_a = 1'b0; clr_b = 1'b0;
    @(negedge clk);

    // R7 single preset input has no effect, then gated preset
    pulse_lo(); model_lo_fall();
    nine_a = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R7 nine_a alone");
    nine_a = 1'b0; nine_b = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R7 nine_b alone");
    nine_a = 1'b1;
    @(negedge clk);
    model_load(9);
    check_all("R7 gated preset nine");
    nine_a = 1'b0; nine_b = 1'b0;
    @(negedge clk);

    // R4 R5 wraps from the preset value
    pulse_lo(); model_lo_fall();
    check_all("R4 nine to zero on lo fall");
    model_load(9);
    nine_a = 1'b1; nine_b = 1'b1;
    @(negedge clk);
    nine_a = 1'b0; nine_b = 1'b0;
    @(negedge clk);
    pulse_hi(); model_hi_fall();
    check_all("R5 nine to zero on hi fall");

    // R8 clear beats preset
    nine_a = 1'b1; nine_b = 1'b1;
    @(negedge clk);
    nine_a = 1'b0; nine_b = 1'b0;
    @(negedge clk);
    model_load(9);
    check_all("R8 setup nine");
    clr_a = 1'b1; clr_b = 1'b1; nine_a = 1'b1; nine_b = 1'b1;
    @(negedge clk);
    model_load(0);
    check_all("R8 clear over preset");
    clr_a = 1'b0; clr_b = 1'b0; nine_a = 1'b0; nine_b = 1'b0;
    @(negedge clk);

    // R9 clocks ignored during a clear hold
    pulse_hi(); pulse_hi(); model_hi_fall(); model_hi_fall();
    check_all("R9 pre-hold count");
    clr_a = 1'b1; clr_b = 1'b1;
    @(negedge clk);
    model_load(0);
    pulse_lo(); pulse_hi();
    check_all("R9 during clear hold");
    clr_a = 1'b0; clr_b = 1'b0;
    repeat (4) @(negedge clk);
    check_all("R9 after clear release");

    // R9 clocks ignored during a preset hold
    nine_a = 1'b1; nine_b = 1'b1;
    @(negedge clk);
    model_load(9);
    pulse_lo(); pulse_hi();
    check_all("R9 during preset hold");
    nine_a = 1'b0; nine_b = 1'b0;
    repeat (4) @(negedge clk);
    check_all("R9 after preset release");
    pulse_lo(); model_lo_fall();
    check_all("R9 resume lo");
    pulse_hi(); model_hi_fall();
    check_all("R9 resume hi");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule